// File: doc/BRIEF.md
# Register-indexed stride value predictor

This block guesses the next value that will be written into a CPU destination register. It holds one entry per logical register and is addressed by register number, not by program counter. The lookup port is presented once decode knows which register an instruction writes. One cycle later the block returns a valid flag and a predicted value, so that dependent instructions can start speculatively.

Each entry remembers the last value written and the last two differences (strides) between consecutive values. A prediction is the last value plus the stride, and is offered only when both remembered strides agree. Each entry also has a two-bit saturating confidence counter, and the stride must have proven itself often enough for that counter to reach its upper half.

After execution, the update port delivers the real result with its register number and trains the entry. A static per-register eligibility mask excludes registers from both lookup and training. Re-issue after a wrong guess is handled outside this block.

Top module: `reg_stride_vpred`

## Requirements
- R1: While rst_n is low and after it, every entry is empty and pred_valid and pred_value are 0. A lookup of any register before its first write returns no prediction.
- R2: pred_valid and pred_value appear exactly one clock after lkp_valid is sampled high and hold for that one cycle only. Whenever pred_valid is 0, pred_value is 0.
- R3: The first three writes to a register only collect history. They store the value, then the first stride, then shift that stride into the older slot. No prediction is possible until three writes have been made.
- R4: The predicted value is the stored last value plus the stored stride, computed modulo 2^DATA_W, so negative strides and wrap-around work.
- R5: Confidence is a counter from 0 to 3 that saturates at both ends. It is cleared on the first write. From the fourth write on, it goes up when the write equals last value plus stride with both strides equal, and down otherwise. A prediction needs confidence 2 or 3.
- R6: When the two stored strides differ, no prediction is issued, whatever the confidence.
- R7: A register whose bit in eligible_mask is 0 yields no prediction on lookup, and updates to it leave its entry unchanged.
- R8: A lookup and an update to the same register in the same cycle return the prediction from the entry state before that update.
- R9: An update trains only the entry named by upd_reg. All other entries keep their state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, empties all entries |
| eligible_mask | input | NUM_REGS | Bit i set allows lookup and training of register i |
| lkp_valid | input | 1 | Lookup request |
| lkp_reg | input | IDX_W | Destination register number to look up |
| upd_valid | input | 1 | Training request with a real result |
| upd_reg | input | IDX_W | Register number that received the result |
| upd_value | input | DATA_W | Real value written to the register |
| pred_valid | output | 1 | A prediction is offered (one cycle after lookup) |
| pred_value | output | DATA_W | Predicted value, 0 when pred_valid is 0 |

## Verification
The bench builds the block with eight registers and an 8-bit data path. With this narrow path, stride arithmetic that wraps past 255 and negative strides can be checked in a few writes, and several registers can be trained side by side to show they stay independent. Long training runs drive the confidence counter into saturation, so the cycle counts of later decrements show whether it saturated or wrapped. A masked register is trained, masked, written and unmasked, so its untouched state can be read back through a normal lookup.

// File: rtl/vpred_pkg.sv
package vpred_pkg;

  // History phase of one entry: how many writes have been seen so far.
  typedef enum logic [1:0] {
    PH_EMPTY = 2'd0,
    PH_VAL   = 2'd1,
    PH_STR1  = 2'd2,
    PH_FULL  = 2'd3
  } phase_t;

  typedef logic [1:0] conf_t;

  localparam conf_t CONF_MAX  = 2'd3;
  localparam conf_t CONF_GATE = 2'd2;

  // Saturating step of the confidence automaton.
  function automatic conf_t conf_step(input conf_t c, input logic hit);
    if (hit) return (c == CONF_MAX) ? c : c + 2'd1;
    else     return (c == 2'd0)     ? c : c - 2'd1;
  endfunction

  function automatic logic conf_trusted(input conf_t c);
    return c >= CONF_GATE;
  endfunction

endpackage

// File: rtl/vpred_entry.sv
module vpred_entry
  import vpred_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_value,
  output phase_t            phase,
  output conf_t             conf,
  output logic              cand_ok,
  output logic [DATA_W-1:0] cand_value
);

  function automatic logic [DATA_W-1:0] stride_of(input logic [DATA_W-1:0] nv,
                                                  input logic [DATA_W-1:0] ov);
    return nv - ov;
  endfunction

  function automatic logic [DATA_W-1:0] project(input logic [DATA_W-1:0] v,
                                                input logic [DATA_W-1:0] s);
    return v + s;
  endfunction

  logic [DATA_W-1:0] last_q, str1_q, str2_q;
  phase_t            phase_q;
  conf_t             conf_q;
  logic [DATA_W-1:0] new_stride;
  logic              hit;

  assign new_stride = stride_of(wr_value, last_q);
  assign cand_ok    = (phase_q == PH_FULL) && (str1_q == str2_q);
  assign cand_value = project(last_q, str2_q);
  assign hit        = cand_ok && (wr_value == cand_value);
  assign phase      = phase_q;
  assign conf       = conf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      str1_q  <= '0;
      str2_q  <= '0;
      conf_q  <= '0;
      phase_q <= PH_EMPTY;
    end else if (wr_en) begin
      last_q <= wr_value;
      case (phase_q)
        PH_EMPTY: begin
          conf_q  <= '0;
          phase_q <= PH_VAL;
        end
        PH_VAL: begin
          str1_q  <= new_stride;
          phase_q <= PH_STR1;
        end
        PH_STR1: begin
          str2_q  <= str1_q;
          str1_q  <= new_stride;
          phase_q <= PH_FULL;
        end
        default: begin
          str2_q <= str1_q;
          str1_q <= new_stride;
          conf_q <= conf_step(conf_q, hit);
        end
      endcase
    end
  end

endmodule

// File: rtl/reg_stride_vpred.sv
module reg_stride_vpred
  import vpred_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_REGS-1:0] eligible_mask,
  input  logic                lkp_valid,
  input  logic [IDX_W-1:0]    lkp_reg,
  input  logic                upd_valid,
  input  logic [IDX_W-1:0]    upd_reg,
  input  logic [DATA_W-1:0]   upd_value,
  output logic                pred_valid,
  output logic [DATA_W-1:0]   pred_value
);

  // Per-entry signals, brought out for the checker.
  logic [NUM_REGS-1:0] ent_wr;
  logic [NUM_REGS-1:0] ent_ok;
  logic [DATA_W-1:0]   ent_cand  [NUM_REGS];
  conf_t               ent_conf  [NUM_REGS];
  phase_t              ent_phase [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    assign ent_wr[g] = upd_valid && eligible_mask[g] && (upd_reg == IDX_W'(g));

    vpred_entry #(.DATA_W(DATA_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (ent_wr[g]),
      .wr_value   (upd_value),
      .phase      (ent_phase[g]),
      .conf       (ent_conf[g]),
      .cand_ok    (ent_ok[g]),
      .cand_value (ent_cand[g])
    );
  end

  // Selected entry for the lookup (read before any same-cycle update).
  conf_t             sel_conf;
  phase_t            sel_phase;
  logic              sel_fire;
  logic [DATA_W-1:0] sel_value;

  assign sel_conf  = ent_conf[lkp_reg];
  assign sel_phase = ent_phase[lkp_reg];
  assign sel_value = ent_cand[lkp_reg];
  assign sel_fire  = lkp_valid && eligible_mask[lkp_reg] && ent_ok[lkp_reg]
                     && conf_trusted(sel_conf);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid <= 1'b0;
      pred_value <= '0;
    end else begin
      pred_valid <= sel_fire;
      pred_value <= sel_fire ? sel_value : '0;
    end
  end

endmodule

// File: rtl/vpred_checker.sv
module vpred_checker
  import vpred_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_REGS-1:0] eligible_mask,
  input logic                lkp_valid,
  input logic [IDX_W-1:0]    lkp_reg,
  input logic                upd_valid,
  input logic [IDX_W-1:0]    upd_reg,
  input logic                pred_valid,
  input logic [DATA_W-1:0]   pred_value,
  input logic [NUM_REGS-1:0] ent_wr,
  input conf_t               sel_conf,
  input phase_t              sel_phase
);

  assert_lookup_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> $past(lkp_valid));

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_valid |-> (pred_value == '0));

  assert_history_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> ($past(sel_phase) == PH_FULL));

  assert_conf_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> ($past(sel_conf) >= CONF_GATE));

  assert_masked_lookup_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pred_valid |-> $past(eligible_mask[lkp_reg]));

  assert_masked_train_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !eligible_mask[upd_reg]) |-> (ent_wr == '0));

  assert_single_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ent_wr));

endmodule

bind reg_stride_vpred vpred_checker #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W)
) u_vpred_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .eligible_mask (eligible_mask),
  .lkp_valid     (lkp_valid),
  .lkp_reg       (lkp_reg),
  .upd_valid     (upd_valid),
  .upd_reg       (upd_reg),
  .pred_valid    (pred_valid),
  .pred_value    (pred_value),
  .ent_wr        (ent_wr),
  .sel_conf      (sel_conf),
  .sel_phase     (sel_phase)
);

// File: tb/test_reg_stride_vpred.sv
module test_reg_stride_vpred;

  localparam int NR = 8;
  localparam int DW = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NR-1:0] eligible_mask = '1;
  logic          lkp_valid = 1'b0;
  logic [IW-1:0] lkp_reg = '0;
  logic          upd_valid = 1'b0;
  logic [IW-1:0] upd_reg = '0;
  logic [DW-1:0] upd_value = '0;
  logic          pred_valid;
  logic [DW-1:0] pred_value;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  reg_stride_vpred #(.NUM_REGS(NR), .DATA_W(DW)) i_reg_stride_vpred (
    .clk(clk), .rst_n(rst_n), .eligible_mask(eligible_mask),
    .lkp_valid(lkp_valid), .lkp_reg(lkp_reg),
    .upd_valid(upd_valid), .upd_reg(upd_reg), .upd_value(upd_value),
    .pred_valid(pred_valid), .pred_value(pred_value)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input int r, input int v);
    @(negedge clk);
    upd_valid = 1'b1; upd_reg = IW'(r); upd_value = DW'(v);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // Lookup, sample one edge later, then confirm the result lasts one cycle.
  task automatic lookup(input string req, input int r, input bit exp_v, input int exp_val);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_reg = IW'(r);
    @(negedge clk);
    lkp_valid = 1'b0;
    check({req, " valid"}, int'(pred_valid), int'(exp_v));
    check({req, " value"}, int'(pred_value), exp_v ? (exp_val & 8'hFF) : 0);
    @(negedge clk);
    check("R2 one-cycle pulse", int'(pred_valid), 0);
  endtask

  task automatic t_reset();
    check("R1 reset valid", int'(pred_valid), 0);
    check("R1 reset value", int'(pred_value), 0);
    lookup("R1 empty entry", 0, 0, 0);
  endtask

  task automatic t_warmup();
    write_reg(0, 10); lookup("R3 after write 1", 0, 0, 0);
    write_reg(0, 13); lookup("R3 after write 2", 0, 0, 0);
    write_reg(0, 16); lookup("R3 after write 3", 0, 0, 0);
    write_reg(0, 19); lookup("R5 confidence 1", 0, 0, 0);
    write_reg(0, 22); lookup("R4 R5 first prediction", 0, 1, 25);
  endtask

  task automatic t_negative();
    for (int i = 0; i < 5; i++) write_reg(2, 100 - 10 * i);
    lookup("R4 negative stride", 2, 1, 50);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 5; i++) write_reg(3, 235 + 5 * i);
    lookup("R4 wrap", 3, 1, 4);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 9; i++) write_reg(4, i);
    lookup("R5 saturated", 4, 1, 9);
    write_reg(4, 20);
    lookup("R6 strides differ", 4, 0, 0);
    write_reg(4, 32);
    lookup("R5 decremented below gate", 4, 0, 0);
    write_reg(4, 44);
    lookup("R5 regained", 4, 1, 56);
  endtask

  task automatic t_mask();
    for (int i = 0; i < 5; i++) write_reg(5, 2 * i);
    lookup("R7 trained", 5, 1, 10);
    eligible_mask[5] = 1'b0;
    lookup("R7 masked lookup", 5, 0, 0);
    write_reg(5, 50);
    write_reg(5, 90);
    eligible_mask[5] = 1'b1;
    lookup("R7 masked updates ignored", 5, 1, 10);
  endtask

  task automatic t_same_cycle();
    for (int i = 1; i <= 5; i++) write_reg(1, 10 * i);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_reg = 3'd1;
    upd_valid = 1'b1; upd_reg = 3'd1; upd_value = 8'd60;
    @(negedge clk);
    lkp_valid = 1'b0; upd_valid = 1'b0;
    check("R8 pre-update valid", int'(pred_valid), 1);
    check("R8 pre-update value", int'(pred_value), 60);
    lookup("R8 post-update", 1, 1, 70);
  endtask

  task automatic t_independent();
    lookup("R9 untouched entry", 6, 0, 0);
    write_reg(7, 200);
    lookup("R9 neighbour kept", 0, 1, 25);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_warmup();
    t_negative();
    t_wrap();
    t_saturate();
    t_mask();
    t_same_cycle();
    t_independent();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule